// File: doc/BRIEF.md
# Microsecond Free-Running Timer

This block keeps a 12-bit count that steps once per microsecond. The microsecond tick comes from a prescaler that divides the system clock by a fixed ratio. With a 6 MHz clock the ratio is 6, and with a 12 MHz clock it is 12. The count wraps after 4096 µs, so firmware can time intervals of roughly 4 ms. The count also drives two periodic interrupt requests. One fires every 128 µs and the other every 1024 µs. Each is a single-cycle pulse that an interrupt controller outside the block registers.

Firmware reads the count as two bytes through one 8-bit read port, using one strobe per byte. A low-byte read returns count bits [7:0] and, on the same edge, copies bits [11:8] into a holding register. A later high-byte read returns that copy. The two bytes therefore form one coherent value, even if the counter carried into the upper nibble between the two reads.

Top module: `usec_timer`

## Requirements
- R1: Synchronous reset clears the count, the nibble holding register, the read data and both interrupt outputs. A high-byte read made before any low-byte read returns 0x00.
- R2: The count steps by one every CLK_DIV clock cycles (6 or 12). After reset is released, the first step takes effect on clock edge CLK_DIV+1, counting the first edge with reset low as edge 1.
- R3: The count is 12 bits wide and goes from 0xFFF to 0x000 on the step after 0xFFF.
- R4: A low-byte strobe sampled on an edge loads the read data with count bits [7:0] as they stood just before that edge. On the same edge it copies count bits [11:8] into the holding register.
- R5: A high-byte strobe loads the read data with the held nibble in bits [3:0] and zeros in bits [7:4]. The counter advancing after the low-byte read does not change this value.
- R6: When both strobes are sampled on the same edge, the low-byte read takes effect and the high-byte strobe is ignored.
- R7: On an edge with no strobe, the read data keeps its previous value.
- R8: The 128 µs output pulses high for exactly one cycle when the count steps to a value whose bits [6:0] are zero. That pulse is in the same cycle the new value is first held, so the pulses come every 128 steps.
- R9: The 1024 µs output pulses high for one cycle when the count steps to a value whose bits [9:0] are zero. Every such pulse coincides with a 128 µs pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (6 or 12 MHz in use) |
| rst | input | 1 | Synchronous active-high reset |
| rd_lo_i | input | 1 | Low-byte read strobe, one cycle |
| rd_hi_i | input | 1 | High-byte read strobe, one cycle |
| rdata_o | output | 8 | Registered read data |
| irq_fast_o | output | 1 | 128 µs interrupt request pulse |
| irq_slow_o | output | 1 | 1024 µs interrupt request pulse |

## Verification
The bench builds two copies of the block, one with the default divide-by-6 prescaler and one with divide-by-12. Both run from a common reset, so the step timing and the first 128 µs pulse can be checked for each ratio against a cycle-count formula. The divide-by-6 copy runs through a full 4096-step wrap in about 25 000 cycles. That covers the 0xFFF to 0x000 step, where both interrupts fire together. It also gives enough time for the upper nibble to change between a low-byte and a high-byte read, which exercises the holding register.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

  typedef enum logic [1:0] {
    RSEL_IDLE = 2'd0,
    RSEL_LOW  = 2'd1,
    RSEL_HIGH = 2'd2
  } rsel_e;

  function automatic rsel_e decode_rsel(input logic lo, input logic hi);
    if (lo)      return RSEL_LOW;
    else if (hi) return RSEL_HIGH;
    else         return RSEL_IDLE;
  endfunction

endpackage

// File: rtl/usec_prescaler.sv
module usec_prescaler #(
  parameter int CLK_DIV = 6
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(CLK_DIV - 1);

  logic tick_q;

  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= 1'b1;
      end
    end else begin : g_div
      logic [PW-1:0] phase_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          phase_q <= '0;
          tick_q  <= 1'b0;
        end else if (phase_q == PH_LAST) begin
          phase_q <= '0;
          tick_q  <= 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
          tick_q  <= 1'b0;
        end
      end
    end
  endgenerate

  assign tick_o = tick_q;
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/usec_tap.sv
module usec_tap #(
  parameter int CNT_W = 12,
  parameter int TAP   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             irq_o
);
  logic irq_q;

  // A step from all-ones in the low TAP bits lands on zero there.
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= step_i && (&cnt_i[TAP-1:0]);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/usec_read_port.sv
module usec_read_port
  import usec_timer_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [HI_W-1:0]   hold_q;
  logic [DATA_W-1:0] rdata_q;
  rsel_e             sel;

  assign sel = decode_rsel(rd_lo_i, rd_hi_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (sel)
        RSEL_LOW: begin
          rdata_q <= cnt_i[DATA_W-1:0];
          hold_q  <= cnt_i[CNT_W-1:DATA_W];
        end
        RSEL_HIGH: rdata_q <= DATA_W'(hold_q);
        default:   rdata_q <= rdata_q;
      endcase
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/usec_timer.sv
module usec_timer #(
  parameter int CLK_DIV  = 6,
  parameter int CNT_W    = 12,
  parameter int DATA_W   = 8,
  parameter int FAST_TAP = 7,
  parameter int SLOW_TAP = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_fast_o,
  output logic              irq_slow_o
);
  localparam int NUM_TAPS = 2;
  localparam int TAPS [NUM_TAPS] = '{FAST_TAP, SLOW_TAP};

  logic             tick_w;
  logic [CNT_W-1:0] count_w;
  logic [NUM_TAPS-1:0] irq_w;

  usec_prescaler #(.CLK_DIV(CLK_DIV)) u_presc (
    .clk(clk), .rst(rst), .tick_o(tick_w)
  );

  usec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step_i(tick_w), .cnt_o(count_w)
  );

  genvar t;
  generate
    for (t = 0; t < NUM_TAPS; t++) begin : g_tap
      usec_tap #(.CNT_W(CNT_W), .TAP(TAPS[t])) u_tap (
        .clk(clk), .rst(rst), .step_i(tick_w), .cnt_i(count_w), .irq_o(irq_w[t])
      );
    end
  endgenerate

  usec_read_port #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i),
    .cnt_i(count_w), .rdata_o(rdata_o)
  );

  assign irq_fast_o = irq_w[0];
  assign irq_slow_o = irq_w[1];
endmodule

// File: rtl/usec_timer_checker.sv
module usec_timer_checker #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_fast,
  input logic              irq_slow,
  input logic [CNT_W-1:0]  cnt
);
  // R1: reset leaves outputs cleared
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rdata == '0 && !irq_fast && !irq_slow));

  // R2, R3: count moves by at most one per cycle, wrapping in CNT_W bits
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R5: high-byte data carries zeros above the nibble
  a_r5_hi_zero_top: assert property (@(posedge clk) disable iff (rst)
    (rd_hi && !rd_lo) |=> (rdata[DATA_W-1:CNT_W-DATA_W] == '0));

  // R7: read data holds without a strobe
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !(rd_lo || rd_hi) |=> $stable(rdata));

  // R8: fast request is a single-cycle pulse
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_fast |=> !irq_fast);

  // R8: fast request only when low seven count bits are zero
  a_r8_on_boundary: assert property (@(posedge clk) disable iff (rst)
    irq_fast |-> (cnt[6:0] == '0));

  // R9: slow request coincides with fast request
  a_r9_nested: assert property (@(posedge clk) disable iff (rst)
    irq_slow |-> irq_fast);
endmodule

bind usec_timer usec_timer_checker u_chk (
  .clk(clk), .rst(rst), .rd_lo(rd_lo_i), .rd_hi(rd_hi_i),
  .rdata(rdata_o), .irq_fast(irq_fast_o), .irq_slow(irq_slow_o), .cnt(count_w)
);

// File: tb/usec_timer_bench.sv
module usec_timer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_lo = 1'b0, rd_hi = 1'b0;
  logic rd_lo12 = 1'b0, rd_hi12 = 1'b0;
  logic [7:0] rdata, rdata12;
  logic irq_f, irq_s, irq_f12, irq_s12;

  int total = 0, failed = 0;
  int m = 0;
  int mon_err = 0, fast_n = 0, slow_n = 0, first12 = 0;
  int last_nib = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usec_timer u_usec_timer (
    .clk(clk), .rst(rst), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
    .rdata_o(rdata), .irq_fast_o(irq_f), .irq_slow_o(irq_s)
  );

  usec_timer #(.CLK_DIV(12)) u_usec_timer_d12 (
    .clk(clk), .rst(rst), .rd_lo_i(rd_lo12), .rd_hi_i(rd_hi12),
    .rdata_o(rdata12), .irq_fast_o(irq_f12), .irq_slow_o(irq_s12)
  );

  always @(posedge clk) begin
    if (rst) m <= 0;
    else     m <= m + 1;
  end

  function automatic int exp_cnt(int n, int div);
    if (n < 1) return 0;
    return ((n - 1) / div) % 4096;
  endfunction

  function automatic bit stepped(int n, int div);
    return (n > 1) && ((n - 1) % div == 0);
  endfunction

  // Pulse monitor for R8/R9 on both copies
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ef, es, ef12;
      ef   = stepped(m, 6)  && (exp_cnt(m, 6) % 128 == 0);
      es   = stepped(m, 6)  && (exp_cnt(m, 6) % 1024 == 0);
      ef12 = stepped(m, 12) && (exp_cnt(m, 12) % 128 == 0);
      if (irq_f !== ef || irq_s !== es || irq_f12 !== ef12) begin
        mon_err++;
        if (mon_err < 5)
          $display("monitor mismatch at edge %0d: fast %b/%b slow %b/%b fast12 %b/%b",
                   m, irq_f, ef, irq_s, es, irq_f12, ef12);
      end
      if (irq_f) fast_n++;
      if (irq_s) slow_n++;
      if (irq_f12 && first12 == 0) first12 = m;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_edge(int target);
    while (m < target) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    fast_n = 0; slow_n = 0; first12 = 0;
    rst = 1'b0;
  endtask

  task automatic read_lo(string req);
    int at;
    @(negedge clk); rd_lo = 1'b1;
    @(negedge clk); rd_lo = 1'b0;
    at = m;
    chk(req, int'(rdata), exp_cnt(at - 1, 6) % 256);
    last_nib = exp_cnt(at - 1, 6) / 256;
  endtask

  task automatic read_hi(string req, int exp_nib);
    @(negedge clk); rd_hi = 1'b1;
    @(negedge clk); rd_hi = 1'b0;
    chk(req, int'(rdata), exp_nib);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R1 rdata in reset", int'(rdata), 0);
    chk("R1 fast irq in reset", int'(irq_f), 0);
    chk("R1 slow irq in reset", int'(irq_s), 0);
    do_reset();
    read_hi("R1 hi before any lo", 0);
  endtask

  task automatic t_step_timing();
    wait_edge(20);
    read_lo("R2 R4 early low read");
    wait_edge(333);
    read_lo("R2 R4 mid low read");
    wait_edge(1000);
    read_lo("R2 R4 later low read");
  endtask

  task automatic t_coherent();
    int held;
    wait_edge(1500);
    read_lo("R4 low before carry");
    held = last_nib;
    wait_edge(2600);
    read_hi("R5 hi returns held nibble after carry", held);
    read_lo("R4 low after carry");
    chk("R5 nibble advanced", last_nib, 1);
    read_hi("R5 hi new nibble", last_nib);
  endtask

  task automatic t_both();
    int at;
    wait_edge(4000);
    @(negedge clk); rd_lo = 1'b1; rd_hi = 1'b1;
    @(negedge clk); rd_lo = 1'b0; rd_hi = 1'b0;
    at = m;
    chk("R6 both strobes give low byte", int'(rdata), exp_cnt(at - 1, 6) % 256);
    read_hi("R6 latch updated by dual strobe", exp_cnt(at - 1, 6) / 256);
  endtask

  task automatic t_hold();
    logic [7:0] snap;
    read_lo("R7 setup read");
    snap = rdata;
    repeat (60) @(negedge clk);
    chk("R7 rdata holds while counting", int'(rdata), int'(snap));
  endtask

  task automatic t_wrap();
    wait_edge(4096 * 6 + 1 + 6 * 20);
    read_lo("R3 low after wrap");
    read_hi("R3 hi after wrap", 0);
    chk("R8 fast pulses through wrap", fast_n, 32);
    chk("R9 slow pulses through wrap", slow_n, 4);
    chk("R8 R9 pulse pattern", mon_err, 0);
  endtask

  task automatic t_div12();
    int at;
    chk("R2 div12 first fast pulse edge", first12, 128 * 12 + 1);
    @(negedge clk); rd_lo12 = 1'b1;
    @(negedge clk); rd_lo12 = 1'b0;
    at = m;
    chk("R2 div12 low read", int'(rdata12), exp_cnt(at - 1, 12) % 256);
  endtask

  task automatic t_mid_reset();
    read_lo("R1 pre-reset read");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 rdata cleared mid-run", int'(rdata), 0);
    chk("R1 fast irq cleared", int'(irq_f), 0);
    @(negedge clk); rst = 1'b0;
    read_hi("R1 latch cleared by reset", 0);
    wait_edge(50);
    read_lo("R2 count restarts from zero");
  endtask

  initial begin
    t_reset_state();
    t_step_timing();
    t_coherent();
    t_both();
    t_hold();
    t_wrap();
    t_div12();
    t_mid_reset();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule